// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block keeps the in-flight loads of an out-of-order core in a circular queue, oldest at the head and youngest at the tail. Each load gets a slot in program order when it is allocated. It records where the store queue's tail stood at that moment, and later it receives its effective address. Whenever a load or store executes, the queue looks at the younger loads that have already obtained an address in the same coarse address granule. The oldest such load is a memory-ordering violator, and the pipeline must squash it and fetch it again.

The oldest violator found so far is held in a register until the pipeline reads it. Committed loads leave from the head, up to a given sequence number. A misprediction squash removes loads from the tail that are younger than a given sequence number. The block also reports how many new memory instructions the load and store queues together can take. This count reserves the sentinel slot that a circular queue needs to tell a full queue from an empty one.

Top module: `ldq_order_check`

## Requirements
- R1: After reset the queue is empty, `alloc_idx` is 0, `vio_valid` and `exe_fault` are 0, and `free_cnt` is 8 for the default sizes when `sq_used` is 0.
- R2: An accepted allocate writes the slot at `alloc_idx`, and `alloc_idx` then advances by one, wrapping from DEPTH to 0. An allocate is ignored while DEPTH loads are held, so `alloc_idx` does not move.
- R3: `free_cnt` equals min(DEPTH+1-loads, SQ_DEPTH+1-`sq_used`) minus 1.
- R4: At allocation a load records a store-queue reference. The reference is {1'b0, `sq_tail`} when `sq_used` is nonzero and all ones when the store queue is empty. It is reported on `vio_sq_ref` when that load becomes the violator.
- R5: An entry matches an executing access only if its address has been written, it is not marked uncacheable, and both addresses are equal after dropping the low GRAN_BITS (8) bits.
- R6: An executing load (`exe_is_store`=0) searches from `exe_idx`+1 to the tail. An executing store (`exe_is_store`=1) searches from `exe_idx` itself to the tail.
- R7: When at least one entry matches, the oldest matching entry in the search window is the candidate. The result appears one cycle after the execute request, on `exe_fault`, `vio_idx`, `vio_seq` and `vio_sq_ref`.
- R8: A held violator is replaced only by a candidate with a smaller sequence number. `exe_fault` pulses only when the held violator is set or replaced.
- R9: A cycle with `vio_read`=1 clears the held violator on the following edge.
- R10: A commit frees, in one cycle, the consecutive head entries whose sequence number is at most `cmt_seq`. It stops at the first entry that is younger.
- R11: A squash removes, in one cycle, the consecutive tail entries whose sequence number is greater than `flush_seq`. It also clears a held violator whose sequence number is greater than `flush_seq`.
- R12: When a squash and a commit arrive in the same cycle, the commit is ignored. An allocate in a squash cycle is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocate one load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| alloc_idx | output | IW=clog2(DEPTH+1) | Slot the next allocation takes (tail) |
| sq_tail | input | SW=clog2(SQ_DEPTH+1) | Current store-queue tail index |
| sq_used | input | SW | Current store-queue occupancy |
| upd_valid | input | 1 | Write the effective address of one entry |
| upd_idx | input | IW | Entry receiving the address |
| upd_addr | input | ADDR_W | Effective address |
| upd_uncached | input | 1 | Entry is an uncacheable access |
| exe_valid | input | 1 | Run an ordering check |
| exe_is_store | input | 1 | 1: executing store, 0: executing load |
| exe_idx | input | IW | Load's own slot, or the store's recorded load-queue slot |
| exe_addr | input | ADDR_W | Address of the executing access |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| flush_valid | input | 1 | Squash request |
| flush_seq | input | SEQ_W | Entries with a larger sequence number are removed |
| free_cnt | output | max(IW,SW) | Free entries shared by both queues |
| exe_fault | output | 1 | Ordering violation reported for last cycle's check |
| vio_read | input | 1 | Consume and clear the held violator |
| vio_valid | output | 1 | A violator is held |
| vio_idx | output | IW | Slot of the held violator |
| vio_seq | output | SEQ_W | Sequence number of the held violator |
| vio_sq_ref | output | SW+1 | Store-queue reference recorded by the violator |

## Verification
The assertions rely on these conditions on the inputs:
- Sequence numbers rise strictly with allocation order and never wrap.
- `exe_idx` names an occupied slot.
- `sq_used` never exceeds SQ_DEPTH.
- An address update never targets the slot being allocated in the same cycle.

The bench meets all of these by giving loads sequence numbers that step up by ten from one reset to the next. It sends execute checks only to slots it has just filled, and keeps the store-queue occupancy within its depth. The vector table covers occupancy and the free count. The directed part covers the search windows, the replacement ordering, and the interaction of squash with commit.

// File: rtl/ldq_order_check.sv
module ldq_order_check #(
  parameter int DEPTH     = 8,
  parameter int SQ_DEPTH  = 10,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 8,
  localparam int SLOTS    = DEPTH + 1,
  localparam int SQ_SLOTS = SQ_DEPTH + 1,
  localparam int IW       = $clog2(SLOTS),
  localparam int SW       = $clog2(SQ_SLOTS),
  localparam int RW       = SW + 1,
  localparam int FW       = (IW > SW) ? IW : SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IW-1:0]     alloc_idx,
  input  logic [SW-1:0]     sq_tail,
  input  logic [SW-1:0]     sq_used,
  input  logic              upd_valid,
  input  logic [IW-1:0]     upd_idx,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_uncached,
  input  logic              exe_valid,
  input  logic              exe_is_store,
  input  logic [IW-1:0]     exe_idx,
  input  logic [ADDR_W-1:0] exe_addr,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              flush_valid,
  input  logic [SEQ_W-1:0]  flush_seq,
  output logic [FW-1:0]     free_cnt,
  output logic              exe_fault,
  input  logic              vio_read,
  output logic              vio_valid,
  output logic [IW-1:0]     vio_idx,
  output logic [SEQ_W-1:0]  vio_seq,
  output logic [RW-1:0]     vio_sq_ref
);

  localparam logic [RW-1:0] NO_SQ = '1;

  function automatic logic [IW-1:0] wrapi(input int v);
    return IW'(v % SLOTS);
  endfunction

  logic [IW-1:0]     head, tail, count;
  logic [SEQ_W-1:0]  e_seq  [SLOTS];
  logic [ADDR_W-1:0] e_addr [SLOTS];
  logic              e_aok  [SLOTS];
  logic              e_unc  [SLOTS];
  logic [RW-1:0]     e_ref  [SLOTS];

  logic              full, do_alloc;
  logic              hit, base_valid, replace;
  logic [IW-1:0]     hit_slot;
  int                n_cmt, n_fl;

  assign count     = wrapi(int'(tail) - int'(head) + SLOTS);
  assign full      = (int'(count) == DEPTH);
  assign do_alloc  = alloc_valid && !flush_valid && !full;
  assign alloc_idx = tail;

  always_comb begin
    int lqf, sqf, m;
    lqf = SLOTS - int'(count);
    sqf = SQ_SLOTS - int'(sq_used);
    m = (lqf < sqf) ? lqf : sqf;
    free_cnt = FW'(m - 1);
  end

  always_comb begin
    int s;
    logic [IW-1:0] j;
    s = (int'(exe_idx) - int'(head) + SLOTS) % SLOTS + (exe_is_store ? 0 : 1);
    hit = 1'b0;
    hit_slot = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      j = wrapi(int'(head) + k);
      if (k >= s && k < int'(count) && e_aok[j] && !e_unc[j] &&
          ((e_addr[j] >> GRAN_BITS) == (exe_addr >> GRAN_BITS))) begin
        hit = 1'b1;
        hit_slot = j;
      end
    end
  end

  always_comb begin
    logic stop;
    logic [IW-1:0] j;
    n_cmt = 0;
    stop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      j = wrapi(int'(head) + k);
      if (!stop && k < int'(count) && e_seq[j] <= cmt_seq) n_cmt = n_cmt + 1;
      else stop = 1'b1;
    end
  end

  always_comb begin
    logic stop;
    logic [IW-1:0] j;
    n_fl = 0;
    stop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      j = wrapi(int'(tail) + SLOTS - 1 - k);
      if (!stop && k < int'(count) && e_seq[j] > flush_seq) n_fl = n_fl + 1;
      else stop = 1'b1;
    end
  end

  assign base_valid = vio_valid && !vio_read && !(flush_valid && vio_seq > flush_seq);
  assign replace    = exe_valid && hit && (!base_valid || e_seq[hit_slot] < vio_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush_valid) begin
      tail <= wrapi(int'(tail) + SLOTS - n_fl);
    end else begin
      if (do_alloc)  tail <= wrapi(int'(tail) + 1);
      if (cmt_valid) head <= wrapi(int'(head) + n_cmt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        e_seq[i]  <= '0;
        e_addr[i] <= '0;
        e_aok[i]  <= 1'b0;
        e_unc[i]  <= 1'b0;
        e_ref[i]  <= NO_SQ;
      end
    end else begin
      if (upd_valid) begin
        e_addr[upd_idx] <= upd_addr;
        e_aok[upd_idx]  <= 1'b1;
        e_unc[upd_idx]  <= upd_uncached;
      end
      if (do_alloc) begin
        e_seq[tail] <= alloc_seq;
        e_aok[tail] <= 1'b0;
        e_unc[tail] <= 1'b0;
        e_ref[tail] <= (sq_used == '0) ? NO_SQ : {1'b0, sq_tail};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vio_valid  <= 1'b0;
      vio_idx    <= '0;
      vio_seq    <= '0;
      vio_sq_ref <= NO_SQ;
      exe_fault  <= 1'b0;
    end else begin
      exe_fault <= replace;
      if (replace) begin
        vio_valid  <= 1'b1;
        vio_idx    <= hit_slot;
        vio_seq    <= e_seq[hit_slot];
        vio_sq_ref <= e_ref[hit_slot];
      end else begin
        vio_valid <= base_valid;
      end
    end
  end

endmodule

// File: rtl/ldq_order_check_chk.sv
module ldq_order_check_chk #(
  parameter int DEPTH    = 8,
  parameter int SQ_DEPTH = 10,
  parameter int SEQ_W    = 16,
  localparam int IW      = $clog2(DEPTH + 1),
  localparam int SW      = $clog2(SQ_DEPTH + 1),
  localparam int FW      = (IW > SW) ? IW : SW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic [IW-1:0]    alloc_idx,
  input logic             exe_valid,
  input logic             flush_valid,
  input logic [SEQ_W-1:0] flush_seq,
  input logic [FW-1:0]    free_cnt,
  input logic             exe_fault,
  input logic             vio_read,
  input logic             vio_valid,
  input logic [SEQ_W-1:0] vio_seq
);

  assert_free_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) <= DEPTH);

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(alloc_idx) <= DEPTH);

  assert_tail_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_valid && !flush_valid |=> $stable(alloc_idx));

  assert_fault_needs_exe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exe_valid |=> !exe_fault);

  assert_fault_sets_vio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exe_fault |-> vio_valid);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vio_read && !exe_valid |=> !vio_valid);

  assert_only_older_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vio_valid && $past(vio_valid) && !$past(vio_read) && !$past(flush_valid)
      |-> vio_seq <= $past(vio_seq));

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && vio_valid && (vio_seq > flush_seq) && !exe_valid |=> !vio_valid);

endmodule

bind ldq_order_check ldq_order_check_chk #(
  .DEPTH(DEPTH), .SQ_DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
  .exe_valid(exe_valid), .flush_valid(flush_valid), .flush_seq(flush_seq),
  .free_cnt(free_cnt), .exe_fault(exe_fault), .vio_read(vio_read),
  .vio_valid(vio_valid), .vio_seq(vio_seq)
);

// File: tb/test_ldq_order_check.sv
`timescale 1ns/1ps
module test_ldq_order_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [15:0] alloc_seq = '0;
  logic [3:0]  alloc_idx;
  logic [3:0]  sq_tail = '0;
  logic [3:0]  sq_used = '0;
  logic        upd_valid = 1'b0;
  logic [3:0]  upd_idx = '0;
  logic [31:0] upd_addr = '0;
  logic        upd_uncached = 1'b0;
  logic        exe_valid = 1'b0;
  logic        exe_is_store = 1'b0;
  logic [3:0]  exe_idx = '0;
  logic [31:0] exe_addr = '0;
  logic        cmt_valid = 1'b0;
  logic [15:0] cmt_seq = '0;
  logic        flush_valid = 1'b0;
  logic [15:0] flush_seq = '0;
  logic [3:0]  free_cnt;
  logic        exe_fault;
  logic        vio_read = 1'b0;
  logic        vio_valid;
  logic [3:0]  vio_idx;
  logic [15:0] vio_seq;
  logic [4:0]  vio_sq_ref;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int seq_ctr = 0;

  ldq_order_check i_ldq_order_check (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .sq_tail(sq_tail), .sq_used(sq_used),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_addr(upd_addr),
    .upd_uncached(upd_uncached), .exe_valid(exe_valid), .exe_is_store(exe_is_store),
    .exe_idx(exe_idx), .exe_addr(exe_addr), .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .flush_valid(flush_valid), .flush_seq(flush_seq), .free_cnt(free_cnt),
    .exe_fault(exe_fault), .vio_read(vio_read), .vio_valid(vio_valid),
    .vio_idx(vio_idx), .vio_seq(vio_seq), .vio_sq_ref(vio_sq_ref)
  );

  always #10 clk = ~clk;

  // rows: {allocs, sq_used, expected free_cnt, expected alloc_idx}
  localparam logic [15:0] VEC [6] = '{
    {4'd0, 4'd0, 4'd8, 4'd0},
    {4'd2, 4'd0, 4'd6, 4'd2},
    {4'd1, 4'd7, 4'd3, 4'd3},
    {4'd3, 4'd0, 4'd2, 4'd6},
    {4'd2, 4'd9, 4'd0, 4'd8},
    {4'd1, 4'd0, 4'd0, 4'd8}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc();
    cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic alloc(input int seq);
    alloc_valid = 1'b1;
    alloc_seq = 16'(seq);
    cyc();
    alloc_valid = 1'b0;
  endtask

  task automatic upd(input int idx, input logic [31:0] a, input logic unc);
    upd_valid = 1'b1;
    upd_idx = 4'(idx);
    upd_addr = a;
    upd_uncached = unc;
    cyc();
    upd_valid = 1'b0;
  endtask

  task automatic exe(input logic st, input int idx, input logic [31:0] a);
    exe_valid = 1'b1;
    exe_is_store = st;
    exe_idx = 4'(idx);
    exe_addr = a;
    cyc();
    exe_valid = 1'b0;
  endtask

  task automatic rd();
    vio_read = 1'b1;
    cyc();
    vio_read = 1'b0;
    chk("R9 read clears violator", int'(vio_valid), 0);
  endtask

  task automatic commit(input int s);
    cmt_valid = 1'b1;
    cmt_seq = 16'(s);
    cyc();
    cmt_valid = 1'b0;
  endtask

  task automatic flush(input int s);
    flush_valid = 1'b1;
    flush_seq = 16'(s);
    cyc();
    flush_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 free after reset", int'(free_cnt), 8);
    chk("R1 alloc_idx after reset", int'(alloc_idx), 0);
    chk("R1 vio_valid after reset", int'(vio_valid), 0);
    chk("R1 exe_fault after reset", int'(exe_fault), 0);

    for (int r = 0; r < 6; r++) begin
      sq_used = VEC[r][11:8];
      for (int n = 0; n < int'(VEC[r][15:12]); n++) begin
        seq_ctr += 10;
        alloc(seq_ctr);
      end
      chk("R3 free count row", int'(free_cnt), int'(VEC[r][7:4]));
      chk("R2 alloc index row", int'(alloc_idx), int'(VEC[r][3:0]));
    end
    sq_used = '0;

    commit(30);
    chk("R10 commit frees prefix", int'(free_cnt), 3);
    commit(35);
    chk("R10 commit stops at younger", int'(free_cnt), 3);
    alloc(90);
    chk("R2 tail wraps to 0", int'(alloc_idx), 0);
    alloc(100);
    alloc(110);
    chk("R2 tail after wrap", int'(alloc_idx), 2);
    chk("R3 full after wrap", int'(free_cnt), 0);

    flush_valid = 1'b1; flush_seq = 16'd95;
    cmt_valid = 1'b1;   cmt_seq = 16'd200;
    alloc_valid = 1'b1; alloc_seq = 16'd999;
    cyc();
    flush_valid = 1'b0; cmt_valid = 1'b0; alloc_valid = 1'b0;
    chk("R12 squash wins tail", int'(alloc_idx), 0);
    chk("R12 commit ignored", int'(free_cnt), 2);

    do_reset();
    sq_used = 4'd2; sq_tail = 4'd5; alloc(100);
    sq_used = 4'd0;                 alloc(110);
    sq_used = 4'd1; sq_tail = 4'd3; alloc(120);
    alloc(130);
    sq_used = 4'd0;                 alloc(140);
    chk("R2 five allocated", int'(alloc_idx), 5);
    upd(1, 32'h1234_0500, 1'b0);
    upd(2, 32'h1234_05FF, 1'b1);
    upd(3, 32'h1234_0510, 1'b0);
    upd(4, 32'h9999_0000, 1'b0);

    exe(1'b0, 0, 32'h1234_05AB);
    chk("R7 load fault next cycle", int'(exe_fault), 1);
    chk("R7 oldest match idx", int'(vio_idx), 1);
    chk("R7 violator seq", int'(vio_seq), 110);
    chk("R4 empty store queue marker", int'(vio_sq_ref), 31);
    cyc();
    chk("R7 fault is one pulse", int'(exe_fault), 0);
    rd();

    exe(1'b0, 1, 32'h1234_05AB);
    chk("R5 uncached skipped", int'(vio_idx), 3);
    chk("R4 recorded store tail", int'(vio_sq_ref), 3);
    rd();

    exe(1'b0, 2, 32'h1234_0600);
    chk("R5 other granule no fault", int'(exe_fault), 0);
    chk("R5 other granule no violator", int'(vio_valid), 0);

    exe(1'b1, 1, 32'h1234_0501);
    chk("R6 store window includes own idx", int'(vio_idx), 1);
    chk("R6 store fault", int'(exe_fault), 1);

    exe(1'b1, 3, 32'h1234_0500);
    chk("R8 younger does not replace fault", int'(exe_fault), 0);
    chk("R8 held violator kept", int'(vio_idx), 1);

    exe(1'b1, 0, 32'h0000_0000);
    chk("R5 unwritten address ignored", int'(exe_fault), 0);

    rd();
    upd(0, 32'h5555_0000, 1'b0);
    exe(1'b1, 0, 32'h5555_00FF);
    chk("R6 store hits own entry", int'(vio_idx), 0);
    chk("R4 store tail at first alloc", int'(vio_sq_ref), 5);
    rd();

    exe(1'b1, 3, 32'h1234_0500);
    chk("R8 set held", int'(vio_idx), 3);
    exe(1'b0, 0, 32'h1234_0500);
    chk("R8 older replaces fault", int'(exe_fault), 1);
    chk("R8 older replaces idx", int'(vio_idx), 1);

    flush(115);
    chk("R11 older violator kept", int'(vio_valid), 1);
    chk("R11 tail after squash", int'(alloc_idx), 2);
    chk("R3 free after squash", int'(free_cnt), 6);
    flush(105);
    chk("R11 younger violator cleared", int'(vio_valid), 0);
    chk("R11 tail after second squash", int'(alloc_idx), 1);

    commit(99);
    chk("R10 nothing committed", int'(free_cnt), 7);
    commit(100);
    chk("R10 head committed", int'(free_cnt), 8);
    chk("R10 tail unchanged by commit", int'(alloc_idx), 1);

    finish_up();
  end
endmodule